// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO

This block stores parallel words in a 1024-entry, 16-bit memory and sends them out one bit at a time on a single serial line. A producer presents a word together with a one-cycle write strobe. A consumer raises a shift enable, and on every cycle in which it is high and a word is in the output shifter, the block moves one bit out. All logic runs on one clock, and the reset is synchronous and active high.

The bit order is chosen per word with a direction input. The level on that input is taken when a word moves into the output shifter, and it holds until the last bit of that word has gone out. A word counts as consumed once its sixteenth bit has left, and only then does it free its memory slot. Read data passes through the memory's registered output into a one-word staging register and then into the shifter. While words are waiting, the next one is already staged, so consecutive words stream without a gap.

A full flag stops further writes, and an empty flag reports that the shifter holds no word. The producer and consumer use these flags for gating.

Top module: `par2ser_fifo`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `empty` is 1, `full` is 0 and `ser_out` is 0. Both memory pointers restart at slot zero, so the first word written after reset is the first word sent out.
- R2: A strobe that arrives while `full` is 1 is dropped. No slot is written and no word is added to the stream.
- R3: A strobe that arrives while `full` is 0 stores the word and raises the occupancy by one. `full` is 1 exactly when the occupancy is 1024, and it rises on the edge that accepts the 1024th word.
- R4: When `empty` is 1, `shift_en` is ignored: no bit is consumed and the word that arrives next starts at its first bit.
- R5: With `msb_first` at 0 when a word enters the shifter, its bits leave as bit 0 first up to bit 15. With `msb_first` at 1, they leave as bit 15 first down to bit 0. On a cycle with `shift_en` high and `empty` low, `ser_out` shows the bit that the next edge consumes.
- R6: The edge that shifts the sixteenth bit of a word lowers the occupancy by one, so `full` falls on that edge. If another word was accepted at least two edges earlier, `empty` stays 0 across that edge and the new word starts on the next cycle. If no word remains, `empty` rises on that edge.
- R7: When a write is accepted on the same edge that completes a word, the occupancy is unchanged.
- R8: When a word is written into a completely empty FIFO, `empty` stays 1 after the accepting edge and after the edge that follows it, and falls on the third edge counted from the accepting one.
- R9: Words leave in the order they were accepted, with their contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 16 | Parallel word to store |
| full | output | 1 | Occupancy has reached 1024 words |
| shift_en | input | 1 | Consume one serial bit this cycle |
| msb_first | input | 1 | Bit order, sampled when a word enters the shifter |
| ser_out | output | 1 | Serial data bit |
| empty | output | 1 | No word is in the output shifter |

## Verification
The assertions take it for granted that the strobe and the shift enable are plain per-cycle levels sampled only at the rising edge. They also assume that direction changes happen only while the FIFO is idle, since the bench cannot see the cycle in which a word enters the shifter. The random stimulus draws the strobe and the enable independently on each cycle, at rates that keep the occupancy both near empty and near full. It flips the direction only after draining, that is, after the reference queue is empty and `empty` is 1. Writes while full and shifts while empty are driven on purpose. Their absence of effect is then judged from the serial bits that come out afterwards.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;
  localparam int unsigned P2S_WIDTH = 16;
  localparam int unsigned P2S_DEPTH = 1024;

  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/par2ser_ram.sv
module par2ser_ram #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/par2ser_ctrl.sv
module par2ser_ctrl #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          empty,
  input  logic          done,
  output logic          full,
  output logic          load,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr
);
  logic [CNTW-1:0] cnt, cnt_nxt, pending;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            stage_vld;
  logic            acc;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign acc     = wr_stb && !full;
  assign cnt_nxt = cnt + CNTW'(acc) - CNTW'(done);
  assign pending = cnt - CNTW'(stage_vld) - CNTW'(!empty);
  assign load    = stage_vld && (empty || done);
  assign re      = (pending != '0) && (!stage_vld || load);
  assign we      = acc;
  assign waddr   = wr_ptr;
  assign raddr   = rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      full      <= 1'b0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      stage_vld <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      full <= (cnt_nxt == CNTW'(DEPTH));
      if (acc) wr_ptr <= bump(wr_ptr);
      if (re) begin
        rd_ptr    <= bump(rd_ptr);
        stage_vld <= 1'b1;
      end else if (load) begin
        stage_vld <= 1'b0;
      end
    end
  end

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_stb) |=> (wr_ptr == $past(wr_ptr)));

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH));

  // R7
  wr_done_same_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && done) |=> (cnt == $past(cnt)));

  // R6
  done_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !acc) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/par2ser_shifter.sv
module par2ser_shifter
  import par2ser_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned BCW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             msb_first,
  input  logic             shift_en,
  output logic             ser_out,
  output logic             empty,
  output logic             done
);
  logic [WIDTH-1:0] sh;
  logic [WIDTH-1:0] rev;
  logic [BCW-1:0]   bitcnt;
  logic             valid;
  bit_order_e       order;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev[i] = load_word[WIDTH-1-i];
  end

  assign order   = bit_order_e'(msb_first);
  assign done    = valid && shift_en && (bitcnt == BCW'(WIDTH - 1));
  assign empty   = !valid;
  assign ser_out = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      bitcnt <= '0;
      valid  <= 1'b0;
    end else if (load) begin
      sh     <= (order == ORDER_MSB) ? rev : load_word;
      bitcnt <= '0;
      valid  <= 1'b1;
    end else if (valid && shift_en) begin
      sh     <= sh >> 1;
      bitcnt <= bitcnt + 1'b1;
      if (done) valid <= 1'b0;
    end
  end

  // R4
  idle_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && shift_en && !load) |=> (empty && $stable(sh)));

  // R8
  empty_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(empty) |-> $past(load));
endmodule

// File: rtl/par2ser_fifo.sv
module par2ser_fifo
  import par2ser_pkg::*;
#(
  parameter int unsigned WIDTH = P2S_WIDTH,
  parameter int unsigned DEPTH = P2S_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             shift_en,
  input  logic             msb_first,
  output logic             ser_out,
  output logic             empty
);
  logic             load, done, we, re;
  logic [AW-1:0]    waddr, raddr;
  logic [WIDTH-1:0] stage_word;

  par2ser_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(wr_stb),
    .empty (empty),
    .done  (done),
    .full  (full),
    .load  (load),
    .we    (we),
    .waddr (waddr),
    .re    (re),
    .raddr (raddr)
  );

  par2ser_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wr_data),
    .re   (re),
    .raddr(raddr),
    .rdata(stage_word)
  );

  par2ser_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_word(stage_word),
    .msb_first(msb_first),
    .shift_en (shift_en),
    .ser_out  (ser_out),
    .empty    (empty),
    .done     (done)
  );
endmodule

// File: tb/test_par2ser_fifo.sv
`timescale 1ns/1ps
module test_par2ser_fifo;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic        shift_en = 1'b0;
  logic        msb_first = 1'b0;
  logic        full, ser_out, empty;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  bit finished = 1'b0;
  int bi = 0;
  int popped = 0;
  logic [15:0] mq[$];
  int          eq[$];

  par2ser_fifo i_par2ser_fifo (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .full(full),
    .shift_en(shift_en), .msb_first(msb_first), .ser_out(ser_out), .empty(empty)
  );

  always #4 clk = ~clk;

  function automatic logic exp_bit(input logic [15:0] w, input int idx, input logic msb);
    return msb ? w[15-idx] : w[idx];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, edge_cnt);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] d, input logic sh);
    logic comp;
    logic eb;
    comp = 1'b0;
    chk(full === (mq.size() == DEPTH), "R3 full flag", 32'(full), 32'(mq.size() == DEPTH));
    wr_stb = wr; wr_data = d; shift_en = sh;
    if (sh && !empty) begin
      if (mq.size() == 0) begin
        chk(1'b0, "R4 bit offered with nothing stored", 32'(empty), 32'd1);
      end else begin
        eb = exp_bit(mq[0], bi, msb_first);
        chk(ser_out === eb, "R5 R9 serial bit", 32'(ser_out), 32'(eb));
        bi++;
        if (bi == 16) begin
          void'(mq.pop_front()); void'(eq.pop_front());
          bi = 0; comp = 1'b1; popped++;
        end
      end
    end
    if (wr && !full) begin
      mq.push_back(d); eq.push_back(edge_cnt + 1);
    end
    @(posedge clk); edge_cnt++;
    @(negedge clk);
    if (comp && mq.size() > 0 && eq[0] <= edge_cnt - 2)
      chk(empty === 1'b0, "R6 next word follows without gap", 32'(empty), 32'd0);
    if (comp && mq.size() == 0)
      chk(empty === 1'b1, "R6 empty after last word", 32'(empty), 32'd1);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(1'b0, 16'h0, 1'b1);
    step(1'b0, 16'h0, 1'b0);
    chk(empty === 1'b1, "R6 drained", 32'(empty), 32'd1);
  endtask

  task automatic mix(input int n, input int pw, input int ps);
    for (int k = 0; k < n; k++)
      step($urandom_range(99) < pw, 16'($urandom()), $urandom_range(99) < ps);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(empty === 1'b1 && full === 1'b0 && ser_out === 1'b0, "R1 reset outputs",
        {29'd0, empty, full, ser_out}, 32'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(empty === 1'b1 && full === 1'b0, "R1 after release", {30'd0, empty, full}, 32'b10);

    // R4: shifting while empty has no effect
    for (int k = 0; k < 20; k++) step(1'b0, 16'h0, 1'b1);
    chk(empty === 1'b1, "R4 still empty", 32'(empty), 32'd1);

    // R8: empty latency, R1 first word out, R5 LSB first
    msb_first = 1'b0;
    step(1'b1, 16'hA5C3, 1'b0);
    chk(empty === 1'b1, "R8 after accept edge", 32'(empty), 32'd1);
    step(1'b0, 16'h0, 1'b0);
    chk(empty === 1'b1, "R8 after second edge", 32'(empty), 32'd1);
    step(1'b0, 16'h0, 1'b0);
    chk(empty === 1'b0, "R8 after third edge", 32'(empty), 32'd0);
    drain();

    // R5: MSB first
    msb_first = 1'b1;
    step(1'b1, 16'h1E77, 1'b0);
    step(1'b1, 16'h8001, 1'b0);
    drain();

    // random traffic in both orders
    msb_first = 1'b0; mix(3000, 40, 70); drain();
    msb_first = 1'b1; mix(3000, 30, 90); drain();
    msb_first = 1'b0; mix(2000, 8, 95); drain();

    // R2 R3: fill to full, extra writes are dropped
    msb_first = 1'b1;
    for (int k = 0; k < DEPTH; k++) step(1'b1, 16'($urandom()), 1'b0);
    chk(full === 1'b1, "R3 full at 1024", 32'(full), 32'd1);
    for (int k = 0; k < 6; k++) step(1'b1, 16'hDEAD, 1'b0);
    chk(mq.size() == DEPTH, "R2 model unchanged", mq.size(), DEPTH);
    // R7 R6: complete a word while writing at full, then hover near full
    for (int k = 0; k < 15; k++) step(1'b0, 16'h0, 1'b1);
    step(1'b1, 16'hBEEF, 1'b1);
    chk(full === 1'b0, "R6 full falls on completion", 32'(full), 32'd0);
    mix(3000, 10, 95);
    mix(3000, 90, 95);
    popped = 0;
    begin
      int left;
      left = mq.size();
      drain();
      chk(popped == left, "R2 R9 word count after drain", popped, left);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", edge_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule